// File: doc/BRIEF.md
# Li-Ion Charge Sequencing Controller

This block sequences one constant-current / constant-voltage charge cycle for a single lithium cell. Analog comparators elsewhere on the chip reduce the battery voltage, charge current, temperature and supply to single-bit flags. A one-millisecond tick paces every timer and deglitch window. The block selects the charge phase (off, pre-charge, fast constant-current, constant-voltage), gates the charge path and reports one status code.

Every phase change that depends on an analog flag waits for that flag to hold for its own deglitch window. If the flag drops before the window ends, the window count restarts from zero. The timeout for a phase counts ticks from the start of that phase and keeps counting while charging is paused for temperature. How a stopped cycle restarts depends on why it stopped. After a timeout, an under-voltage fault or end-of-charge, cycling the enable restarts it. After end-of-charge, auto-recharge can also restart it. After an overcharge, only removing and reapplying the input clears it.

All timer and window lengths are parameters counted in ticks, so that a simulation can use short values.

Top module: `chg_seq_ctrl`

## Requirements
- R1: After reset, and one cycle after `in_valid` is low in any state, `phase` is 0, `path_en` is 0 and `status` is 0 (idle). All timers and window counts are cleared.
- R2: In idle, with `in_valid` and `chg_en` high and no overcharge, the next cycle enters pre-charge (`phase`=1) if `bat_above_pre` is low, or fast CC (`phase`=2) if it is high. While in any charge phase, `status` is 1.
- R3: Pre-charge moves to fast CC only after `bat_above_pre` has been high for `P2F_DG` ticks in a row. A drop of the flag restarts the count.
- R4: When the phase timer reaches its limit, charging stops with `status`=4 and `phase`=0. The limit is `PRE_TMO` ticks in pre-charge, and `FAST_TMO` ticks counted across fast CC and CV together.
- R5: During fast CC, if `bat_above_pre` stays low for `LOW_DG` ticks, charging stops with `status`=5.
- R6: Fast CC moves to CV (`phase`=3) on the cycle after `bat_at_float` is seen high. In CV, if `cur_below_term` stays high for `EOC_DG` ticks, the cycle ends with `status`=2 and `phase`=0.
- R7: When `temp_ok` is low in a charge phase, charging pauses (`phase`=0, `status`=6). The phase timer keeps counting during the pause. When `temp_ok` returns, the paused phase resumes. If the timer expires during the pause, the result is `status`=4.
- R8: If `chg_en` is low without an overcharge, the block returns to idle and its timers clear. Raising `chg_en` again starts a new cycle. This is how a timeout, an under-voltage fault, a deep-discharge fault, a temperature pause or end-of-charge is restarted.
- R9: If `bat_over` is high while `in_valid` is high, the next cycle enters overcharge stop (`status`=3, `phase`=0), from any state. This state ignores `chg_en` and clears only when `in_valid` goes low.
- R10: After end-of-charge with `auto_rechg_en` high, if `bat_below_rechg` stays high for `RECHG_DG` ticks, a new cycle starts. With `auto_rechg_en` low, `status` stays 2.
- R11: During pre-charge, if `bat_below_1v` stays high for `DEAD_DG` ticks, charging stops with `status`=7.
- R12: `path_en` is high exactly when `phase` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse, once per millisecond |
| in_valid | input | 1 | Input supply within its valid range |
| chg_en | input | 1 | Charger enable |
| auto_rechg_en | input | 1 | Allow automatic recharge after end-of-charge |
| bat_above_pre | input | 1 | Battery above the pre-charge threshold |
| bat_at_float | input | 1 | Battery has reached float voltage |
| cur_below_term | input | 1 | Charge current below the termination level |
| bat_below_rechg | input | 1 | Battery below the recharge threshold |
| bat_below_1v | input | 1 | Battery below 1 V |
| bat_over | input | 1 | Battery above the overcharge limit |
| temp_ok | input | 1 | Battery temperature within the charging range |
| phase | output | 2 | 0 off, 1 pre-charge, 2 fast CC, 3 CV |
| path_en | output | 1 | Charge path switch enable |
| status | output | 3 | 0 idle, 1 charging, 2 end-of-charge, 3 overcharge, 4 timeout, 5 under-voltage in fast charge, 6 temperature pause, 7 deep discharge |

## Verification
The assertions check the rules that hold on every clock: input loss forces idle, overcharge entry and its stickiness, enable-low forcing idle, a temperature drop stopping the current phase, CV reached only with the float flag, start-phase selection, and `path_en` agreeing with `phase`. The lengths of the deglitch windows, the restart of a window when its flag drops, timeouts that span a temperature pause, and the restart conditions after each kind of stop need multi-tick histories. Only the bench scenarios can show them, with the bench's cycle model compared against the outputs on every clock.

// File: rtl/chg_pkg.sv
// Shared types for the charge sequencing controller.
// Assumes one clock domain; all encodings are fixed by the port-level contract.
package chg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_FAST  = 3'd2,
        ST_CV    = 3'd3,
        ST_PAUSE = 3'd4,
        ST_DONE  = 3'd5,
        ST_STOP  = 3'd6,
        ST_OVC   = 3'd7
    } chg_state_e;

    localparam logic [1:0] PH_OFF = 2'd0;
    localparam logic [1:0] PH_PRE = 2'd1;
    localparam logic [1:0] PH_CC  = 2'd2;
    localparam logic [1:0] PH_CV  = 2'd3;

    localparam logic [2:0] STS_IDLE = 3'd0;
    localparam logic [2:0] STS_CHG  = 3'd1;
    localparam logic [2:0] STS_EOC  = 3'd2;
    localparam logic [2:0] STS_OVC  = 3'd3;
    localparam logic [2:0] STS_TMO  = 3'd4;
    localparam logic [2:0] STS_LOW  = 3'd5;
    localparam logic [2:0] STS_TEMP = 3'd6;
    localparam logic [2:0] STS_DEAD = 3'd7;

    // Index of each deglitch window in the window bank
    localparam int DG_N    = 5;
    localparam int DG_P2F  = 0;
    localparam int DG_LOW  = 1;
    localparam int DG_EOC  = 2;
    localparam int DG_RCH  = 3;
    localparam int DG_DEAD = 4;

endpackage

// File: rtl/chg_deglitch.sv
// Deglitch window: hit goes high once cond has stayed high for LEN ticks.
// Any cycle with cond low clears the count. Assumes LEN >= 1.
module chg_deglitch #(
    parameter int unsigned LEN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cond,
    output logic hit
);
    localparam int unsigned CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] TOP = CW'(LEN);

    logic [CW-1:0] cnt;

    // Count ticks while the condition holds; saturate at the window length
    always_ff @(posedge clk) begin
        if (!rst_n || !cond) begin
            cnt <= '0;
        end else if (tick && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = cond && (cnt == TOP);

endmodule

// File: rtl/chg_phase_timer.sv
// Phase timeout counter: counts ticks up to lim, and flags expiry.
// Assumes lim changes only in a cycle where clr is high.
module chg_phase_timer #(
    parameter int unsigned W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic [W-1:0] lim,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Clear on request, else advance once per tick until the limit
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick && cnt != lim) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == lim);

endmodule

// File: rtl/chg_fsm.sv
// Charge sequencing state machine. It takes the deglitched events and the
// timer expiry, and decides phase, path and status. Priority: input loss,
// overcharge hold, overcharge entry, enable low, then per-state rules.
module chg_fsm
    import chg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       chg_en,
    input  logic       bat_above_pre,
    input  logic       bat_at_float,
    input  logic       bat_over,
    input  logic       temp_ok,
    input  logic       p2f_hit,
    input  logic       low_hit,
    input  logic       eoc_hit,
    input  logic       rechg_hit,
    input  logic       dead_hit,
    input  logic       tmo,
    output chg_state_e state,
    output logic       in_pre,
    output logic       tmr_clr,
    output logic [1:0] phase,
    output logic       path_en,
    output logic [2:0] status
);
    chg_state_e state_q, state_d, rsm_q, rsm_d;
    logic [2:0] cause_q, cause_d;
    logic       running;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        rsm_d   = rsm_q;
        cause_d = cause_q;
        if (!in_valid) begin
            state_d = ST_IDLE;
        end else if (state_q == ST_OVC) begin
            state_d = ST_OVC;
        end else if (bat_over) begin
            state_d = ST_OVC;
        end else if (!chg_en) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: state_d = bat_above_pre ? ST_FAST : ST_PRE;
                ST_PRE: begin
                    if (tmo) begin
                        state_d = ST_STOP; cause_d = STS_TMO;
                    end else if (dead_hit) begin
                        state_d = ST_STOP; cause_d = STS_DEAD;
                    end else if (!temp_ok) begin
                        state_d = ST_PAUSE; rsm_d = ST_PRE;
                    end else if (p2f_hit) begin
                        state_d = ST_FAST;
                    end
                end
                ST_FAST: begin
                    if (tmo) begin
                        state_d = ST_STOP; cause_d = STS_TMO;
                    end else if (low_hit) begin
                        state_d = ST_STOP; cause_d = STS_LOW;
                    end else if (!temp_ok) begin
                        state_d = ST_PAUSE; rsm_d = ST_FAST;
                    end else if (bat_at_float) begin
                        state_d = ST_CV;
                    end
                end
                ST_CV: begin
                    if (tmo) begin
                        state_d = ST_STOP; cause_d = STS_TMO;
                    end else if (!temp_ok) begin
                        state_d = ST_PAUSE; rsm_d = ST_CV;
                    end else if (eoc_hit) begin
                        state_d = ST_DONE;
                    end
                end
                ST_PAUSE: begin
                    if (tmo) begin
                        state_d = ST_STOP; cause_d = STS_TMO;
                    end else if (temp_ok) begin
                        state_d = rsm_q;
                    end
                end
                ST_DONE: begin
                    if (rechg_hit) state_d = bat_above_pre ? ST_FAST : ST_PRE;
                end
                default: state_d = state_q;
            endcase
        end
    end

    // State, resume target and stop cause registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rsm_q   <= ST_PRE;
            cause_q <= STS_TMO;
        end else begin
            state_q <= state_d;
            rsm_q   <= rsm_d;
            cause_q <= cause_d;
        end
    end

    assign running = (state_q == ST_PRE) || (state_q == ST_FAST) ||
                     (state_q == ST_CV)  || (state_q == ST_PAUSE);
    assign in_pre  = (state_q == ST_PRE) || (state_q == ST_PAUSE && rsm_q == ST_PRE);
    assign tmr_clr = !running || (state_q == ST_PRE && state_d == ST_FAST);
    assign state   = state_q;

    // Output decode from the current state
    always_comb begin
        phase  = PH_OFF;
        status = STS_IDLE;
        case (state_q)
            ST_PRE:   begin phase = PH_PRE; status = STS_CHG; end
            ST_FAST:  begin phase = PH_CC;  status = STS_CHG; end
            ST_CV:    begin phase = PH_CV;  status = STS_CHG; end
            ST_PAUSE: status = STS_TEMP;
            ST_DONE:  status = STS_EOC;
            ST_STOP:  status = cause_q;
            ST_OVC:   status = STS_OVC;
            default:  status = STS_IDLE;
        endcase
    end

    assign path_en = (state_q == ST_PRE) || (state_q == ST_FAST) || (state_q == ST_CV);

endmodule

// File: rtl/chg_seq_ctrl.sv
// Top of the charge sequencing controller. It gates the comparator flags by
// state into a bank of deglitch windows, runs one phase timer whose limit
// follows the phase, and drives the state machine. Lengths are in ticks.
module chg_seq_ctrl
    import chg_pkg::*;
#(
    parameter int unsigned P2F_DG   = 100,
    parameter int unsigned LOW_DG   = 10,
    parameter int unsigned EOC_DG   = 100,
    parameter int unsigned RECHG_DG = 1200,
    parameter int unsigned DEAD_DG  = 16000,
    parameter int unsigned PRE_TMO  = 1800000,
    parameter int unsigned FAST_TMO = 18000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       in_valid,
    input  logic       chg_en,
    input  logic       auto_rechg_en,
    input  logic       bat_above_pre,
    input  logic       bat_at_float,
    input  logic       cur_below_term,
    input  logic       bat_below_rechg,
    input  logic       bat_below_1v,
    input  logic       bat_over,
    input  logic       temp_ok,
    output logic [1:0] phase,
    output logic       path_en,
    output logic [2:0] status
);
    localparam int unsigned TMO_MAX = (PRE_TMO > FAST_TMO) ? PRE_TMO : FAST_TMO;
    localparam int unsigned TW = $clog2(TMO_MAX + 1);
    localparam int unsigned DG_LEN [DG_N] = '{P2F_DG, LOW_DG, EOC_DG, RECHG_DG, DEAD_DG};

    chg_state_e     state;
    logic           in_pre, tmr_clr, tmo;
    logic [DG_N-1:0] dg_cond, dg_hit;
    logic [TW-1:0]  tmo_lim;

    // Each window only counts in the state where its flag matters
    always_comb begin
        dg_cond          = '0;
        dg_cond[DG_P2F]  = (state == ST_PRE)  && bat_above_pre;
        dg_cond[DG_LOW]  = (state == ST_FAST) && !bat_above_pre;
        dg_cond[DG_EOC]  = (state == ST_CV)   && cur_below_term;
        dg_cond[DG_RCH]  = (state == ST_DONE) && bat_below_rechg && auto_rechg_en;
        dg_cond[DG_DEAD] = (state == ST_PRE)  && bat_below_1v;
    end

    for (genvar g = 0; g < DG_N; g++) begin : g_dg
        chg_deglitch #(.LEN(DG_LEN[g])) u_dg (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (ms_tick),
            .cond (dg_cond[g]),
            .hit  (dg_hit[g])
        );
    end

    assign tmo_lim = in_pre ? TW'(PRE_TMO) : TW'(FAST_TMO);

    chg_phase_timer #(.W(TW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (ms_tick),
        .clr    (tmr_clr),
        .lim    (tmo_lim),
        .expired(tmo)
    );

    chg_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .chg_en       (chg_en),
        .bat_above_pre(bat_above_pre),
        .bat_at_float (bat_at_float),
        .bat_over     (bat_over),
        .temp_ok      (temp_ok),
        .p2f_hit      (dg_hit[DG_P2F]),
        .low_hit      (dg_hit[DG_LOW]),
        .eoc_hit      (dg_hit[DG_EOC]),
        .rechg_hit    (dg_hit[DG_RCH]),
        .dead_hit     (dg_hit[DG_DEAD]),
        .tmo          (tmo),
        .state        (state),
        .in_pre       (in_pre),
        .tmr_clr      (tmr_clr),
        .phase        (phase),
        .path_en      (path_en),
        .status       (status)
    );

endmodule

// File: rtl/chg_seq_ctrl_chk.sv
// Port-level checker for chg_seq_ctrl, attached by bind. It checks the rules
// that hold on every clock edge after reset.
module chg_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       chg_en,
    input logic       bat_over,
    input logic       bat_above_pre,
    input logic       bat_at_float,
    input logic       temp_ok,
    input logic [1:0] phase,
    input logic       path_en,
    input logic [2:0] status
);
    a_r1_idle_on_input_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (phase == 2'd0 && status == 3'd0 && !path_en));

    a_r9_ovc_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bat_over) |=> (status == 3'd3));

    a_r9_ovc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && status == 3'd3) |=> (status == 3'd3));

    a_r8_enable_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !chg_en && !bat_over && status != 3'd3) |=> (status == 3'd0));

    a_r7_temp_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chg_en && !bat_over && phase != 2'd0 && !temp_ok) |=> (phase == 2'd0));

    a_r6_cv_needs_float: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && !bat_at_float) |=> (phase != 2'd3));

    a_r2_start_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd0 && in_valid && chg_en && !bat_over && !bat_above_pre) |=> (phase == 2'd1));

    a_r12_path_follows_phase: assert property (@(posedge clk) disable iff (!rst_n)
        path_en == (phase != 2'd0));

endmodule

bind chg_seq_ctrl chg_seq_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .chg_en       (chg_en),
    .bat_over     (bat_over),
    .bat_above_pre(bat_above_pre),
    .bat_at_float (bat_at_float),
    .temp_ok      (temp_ok),
    .phase        (phase),
    .path_en      (path_en),
    .status       (status)
);

// File: tb/tb_chg_seq_ctrl.sv
// Bench: a behavioural cycle model compared on every clock, plus scenario checks.
module tb_chg_seq_ctrl;
    localparam int P2F = 5, LOWD = 3, EOCD = 5, RCHD = 8, DEADD = 10;
    localparam int PRET = 60, FASTT = 150;
    localparam int M_IDLE = 0, M_PRE = 1, M_FAST = 2, M_CV = 3, M_PAUSE = 4,
                   M_DONE = 5, M_STOP = 6, M_OVC = 7;

    logic clk = 0, rst_n = 0, ms_tick = 0;
    logic in_valid = 0, chg_en = 0, auto_rechg_en = 0, bat_above_pre = 0;
    logic bat_at_float = 0, cur_below_term = 0, bat_below_rechg = 0;
    logic bat_below_1v = 0, bat_over = 0, temp_ok = 1;
    logic [1:0] phase;
    logic       path_en;
    logic [2:0] status;

    int tests = 0, fails = 0, tdiv = 0;
    int ms, mr, mc, mt;
    int md [5];

    always #5 clk = ~clk;

    chg_seq_ctrl #(.P2F_DG(P2F), .LOW_DG(LOWD), .EOC_DG(EOCD), .RECHG_DG(RCHD),
                   .DEAD_DG(DEADD), .PRE_TMO(PRET), .FAST_TMO(FASTT)) dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .in_valid(in_valid),
        .chg_en(chg_en), .auto_rechg_en(auto_rechg_en), .bat_above_pre(bat_above_pre),
        .bat_at_float(bat_at_float), .cur_below_term(cur_below_term),
        .bat_below_rechg(bat_below_rechg), .bat_below_1v(bat_below_1v),
        .bat_over(bat_over), .temp_ok(temp_ok), .phase(phase), .path_en(path_en),
        .status(status));

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int dglen(input int k);
        case (k)
            0: return P2F;
            1: return LOWD;
            2: return EOCD;
            3: return RCHD;
            default: return DEADD;
        endcase
    endfunction

    function automatic int exp_phase(input int s);
        if (s == M_PRE) return 1;
        if (s == M_FAST) return 2;
        if (s == M_CV) return 3;
        return 0;
    endfunction

    function automatic int exp_status(input int s, input int c);
        case (s)
            M_PRE, M_FAST, M_CV: return 1;
            M_PAUSE: return 6;
            M_DONE: return 2;
            M_STOP: return c;
            M_OVC: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input int s, input int c);
        case (s)
            M_IDLE: return "R1";
            M_PRE, M_FAST, M_CV: return "R2";
            M_DONE: return "R6";
            M_PAUSE: return "R7";
            M_OVC: return "R9";
            default: return (c == 4) ? "R4" : (c == 5) ? "R5" : "R11";
        endcase
    endfunction

    // Tick source: one pulse every fourth cycle
    always @(negedge clk) begin
        if (!rst_n) begin
            tdiv = 0; ms_tick = 0;
        end else begin
            tdiv = (tdiv + 1) % 4;
            ms_tick = (tdiv == 0);
        end
    end

    // Behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        int ns, nr, nc, lim;
        bit inpre, run, tmo;
        bit c [5];
        bit h [5];
        if (!rst_n) begin
            ms = M_IDLE; mr = M_PRE; mc = 4; mt = 0;
            for (int k = 0; k < 5; k++) md[k] = 0;
        end else begin
            inpre = (ms == M_PRE) || (ms == M_PAUSE && mr == M_PRE);
            lim = inpre ? PRET : FASTT;
            run = (ms >= M_PRE && ms <= M_PAUSE);
            tmo = (mt == lim);
            c[0] = (ms == M_PRE) && bat_above_pre;
            c[1] = (ms == M_FAST) && !bat_above_pre;
            c[2] = (ms == M_CV) && cur_below_term;
            c[3] = (ms == M_DONE) && bat_below_rechg && auto_rechg_en;
            c[4] = (ms == M_PRE) && bat_below_1v;
            for (int k = 0; k < 5; k++) h[k] = c[k] && (md[k] == dglen(k));
            ns = ms; nr = mr; nc = mc;
            if (!in_valid) ns = M_IDLE;
            else if (ms == M_OVC) ns = M_OVC;
            else if (bat_over) ns = M_OVC;
            else if (!chg_en) ns = M_IDLE;
            else if (ms == M_IDLE) ns = bat_above_pre ? M_FAST : M_PRE;
            else if (ms == M_PRE || ms == M_FAST || ms == M_CV) begin
                if (tmo) begin ns = M_STOP; nc = 4; end
                else if (ms == M_PRE && h[4]) begin ns = M_STOP; nc = 7; end
                else if (ms == M_FAST && h[1]) begin ns = M_STOP; nc = 5; end
                else if (!temp_ok) begin ns = M_PAUSE; nr = ms; end
                else if (ms == M_PRE && h[0]) ns = M_FAST;
                else if (ms == M_FAST && bat_at_float) ns = M_CV;
                else if (ms == M_CV && h[2]) ns = M_DONE;
            end else if (ms == M_PAUSE) begin
                if (tmo) begin ns = M_STOP; nc = 4; end
                else if (temp_ok) ns = mr;
            end else if (ms == M_DONE && h[3]) ns = bat_above_pre ? M_FAST : M_PRE;
            for (int k = 0; k < 5; k++) begin
                if (!c[k]) md[k] = 0;
                else if (ms_tick && md[k] < dglen(k)) md[k]++;
            end
            if (!run || (ms == M_PRE && ns == M_FAST)) mt = 0;
            else if (ms_tick && mt < lim) mt++;
            ms = ns; mr = nr; mc = nc;
        end
    end

    // Per-cycle comparison against the model (R12 on every cycle)
    always @(negedge clk) begin
        if (rst_n) begin
            chk({req_of(ms, mc), " model phase"}, phase, exp_phase(ms));
            chk({req_of(ms, mc), " model status"}, status, exp_status(ms, mc));
            chk("R12 path_en", path_en, (exp_phase(ms) != 0) ? 1 : 0);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic toggle_en();
        chg_en = 0; cyc(2); chg_en = 1; cyc(2);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        chk("R1 reset status", status, 0);
        chk("R1 reset phase", phase, 0);
        // R2: start in pre-charge
        in_valid = 1; chg_en = 1; cyc(2);
        chk("R2 start pre", phase, 1);
        chk("R2 charging status", status, 1);
        // R3: short high restarts the window
        bat_above_pre = 1; ticks(2); bat_above_pre = 0; cyc(1);
        chk("R3 glitch ignored", phase, 1);
        bat_above_pre = 1; ticks(7);
        chk("R3 moved to fast", phase, 2);
        // R6: CV and end-of-charge
        bat_at_float = 1; cyc(2);
        chk("R6 cv entry", phase, 3);
        cur_below_term = 1; ticks(8);
        chk("R6 end of charge", status, 2);
        // R10: no auto-recharge when disabled
        bat_below_rechg = 1; ticks(12);
        chk("R10 disabled stays done", status, 2);
        bat_at_float = 0; cur_below_term = 0; auto_rechg_en = 1; ticks(10);
        chk("R10 auto recharge restart", phase, 2);
        // R7: temperature pause and resume
        temp_ok = 0; cyc(2);
        chk("R7 paused status", status, 6);
        chk("R7 paused phase", phase, 0);
        ticks(2); temp_ok = 1; cyc(2);
        chk("R7 resumed", phase, 2);
        // R4: fast timeout counts through the pause
        ticks(160);
        chk("R4 fast timeout", status, 4);
        // R8: enable low to idle, then restart
        chg_en = 0; cyc(2);
        chk("R8 enable low idle", status, 0);
        chg_en = 1; cyc(2);
        chk("R8 restart fast", phase, 2);
        // R5: under-voltage during fast CC
        bat_above_pre = 0; ticks(5);
        chk("R5 low fault", status, 5);
        toggle_en();
        chk("R8 restart after fault", phase, 1);
        // R11: deep discharge in pre-charge
        bat_below_1v = 1; ticks(12);
        chk("R11 dead battery", status, 7);
        bat_below_1v = 0; toggle_en();
        // R9: overcharge latch
        bat_over = 1; cyc(1); bat_over = 0; cyc(1);
        chk("R9 overcharge", status, 3);
        toggle_en();
        chk("R9 enable ignored", status, 3);
        in_valid = 0; cyc(2);
        chk("R1 input loss idle", status, 0);
        in_valid = 1; cyc(2);
        chk("R9 replug restart", phase, 1);
        // R4: pre-charge timeout
        ticks(70);
        chk("R4 pre timeout", status, 4);
        in_valid = 0; cyc(2);
        chk("R1 idle after loss", phase, 0);
        finish_run();
    end
endmodule